// File: doc/BRIEF.md
# I2C Controller Interrupt Status Flags

This block keeps the status flags of an I2C controller and merges them into one interrupt request. The protocol engine reports what happened on the bus with one-cycle event pulses. Each pulse sets a flag. Software, or the data path, then clears that flag through the route that belongs to it:

- a write-one-to-clear register;
- a read of the receive data register;
- a write of the transmit data register;
- a transfer-control write (start, stop, or a new byte count).

The protocol engine, address matching and packet-error-code arithmetic live elsewhere. Only the flag semantics are held here.

Flags are registered. An event seen at a rising clock edge shows on `flags_o` right after that edge. The interrupt request is the combinational OR of every flag masked by its enable bit.

When the peripheral enable is low, every flag returns to its idle value at the next edge:

- transmit-empty (bit 0) goes to 1;
- every other flag goes to 0.

Flag bit map, used by all ports that are `FLAG_W` wide:

| Bit | Flag |
|---|---|
| 0 | transmit empty |
| 1 | transmit interrupt |
| 2 | receive not empty |
| 3 | address match |
| 4 | NACK |
| 5 | stop seen |
| 6 | transfer complete |
| 7 | transfer complete, reload |
| 8 | bus error |
| 9 | arbitration lost |
| 10 | overrun |
| 11 | PEC error |
| 12 | timeout |
| 13 | alert |
| 14 | direction |
| 15 | always 0 |

Top module: `i2c_isr_flags`

## Requirements
- R1: After reset, and one edge after any edge where `enable_i` is low, `flags_o` equals 16'h0001. While disabled, no event or write can change this.
- R2: Bits 3, 4, 5, 8, 9, 10, 11, 12 and 13 are sticky. Each is set by a 1 at the same position of `evt_i` and cleared only by `clr_we_i` with a 1 at that position of `clr_data_i`. A 1 in `evt_i` at any other position has no effect.
- R3: If a set event and a clear for the same flag arrive at the same edge, the flag is 1 afterwards.
- R4: Bit 2 sets on `rx_byte_i` and clears on `rxdr_rd_i`.
- R5: Bits 0 and 1 both set on `tx_empty_i` and both clear on `txdr_wr_i`.
- R6: A status write (`sts_we_i`) with `sts_wdata_i[0]`=1 sets bit 0 and leaves bit 1 unchanged.
- R7: A status write with `sts_wdata_i[1]`=1 behaves as follows:
  - With `nostretch_i` high, it sets bit 1, and `txev_o` pulses high for exactly the cycle after that edge.
  - With `nostretch_i` low, the write is ignored: bit 1 does not change and `txev_o` stays low.
- R8: Bit 7 sets on `cnt_done_i` while `reload_i`=1. It clears on `nbytes_wr_i` only when `nbytes_val_i` is non-zero; a zero value leaves it set.
- R9: Bit 6 sets on `cnt_done_i` only while `reload_i`=0 and `autoend_i`=0. It clears on `start_wr_i` or on `stop_wr_i`.
- R10: Bit 14 takes the value of `dir_i` only at an edge where `evt_i[3]` is 1. It holds its value otherwise.
- R11: With parameter `SMBUS_EN`=0, bits 11, 12 and 13 always read 0.
- R12: `irq_o` is 1 exactly when some bit of `flags_o & irq_en_i` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Peripheral enable |
| nostretch_i | input | 1 | Clock stretching disabled |
| reload_i | input | 1 | Reload mode for byte count |
| autoend_i | input | 1 | Automatic stop after byte count |
| evt_i | input | FLAG_W | Set pulses for sticky flags, one per flag position |
| tx_empty_i | input | 1 | Transmit byte moved to shifter |
| rx_byte_i | input | 1 | Received byte placed in receive register |
| cnt_done_i | input | 1 | Programmed byte count exhausted |
| dir_i | input | 1 | Direction reported with address match |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_data_i | input | FLAG_W | Write-one-to-clear data |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | FLAG_W | Status write data (bits 0 and 1 used) |
| txdr_wr_i | input | 1 | Transmit data register write |
| rxdr_rd_i | input | 1 | Receive data register read |
| start_wr_i | input | 1 | Start control bit written with 1 |
| stop_wr_i | input | 1 | Stop control bit written with 1 |
| nbytes_wr_i | input | 1 | Byte count field written |
| nbytes_val_i | input | NB_W | Value written to byte count |
| irq_en_i | input | FLAG_W | Per-flag interrupt enables |
| flags_o | output | FLAG_W | Flag vector |
| irq_o | output | 1 | Combined interrupt request |
| txev_o | output | 1 | Transmit event from software set |

## Verification
The checker watches several rules on every cycle:

- the disabled idle value;
- that a set event always wins over a same-edge clear;
- that sticky flags hold while no clear is written;
- the set paths for receive, flush, transfer-complete and direction;
- that `txev_o` never pulses while clock stretching is allowed;
- the masked OR on `irq_o`.

Some behaviours show only in the bench's scenarios:

- that clearing works through each flag's own route, and that other routes leave the flag alone;
- that a zero byte-count write leaves the reload flag set;
- that auto-end blocks transfer-complete;
- that an event bit at a non-sticky position does nothing;
- that a build without the SMBus flags reports them as 0.

// File: rtl/i2c_isr_pkg.sv
// Package: flag bit positions and derived masks for the I2C status flags.
// Assumes a fixed 16-bit flag vector; bit 15 is unused and reads 0.
package i2c_isr_pkg;
    localparam int FLAG_W   = 16;
    localparam int B_TXE    = 0;
    localparam int B_TXIS   = 1;
    localparam int B_RXNE   = 2;
    localparam int B_ADDR   = 3;
    localparam int B_NACK   = 4;
    localparam int B_STOP   = 5;
    localparam int B_TC     = 6;
    localparam int B_TCR    = 7;
    localparam int B_BERR   = 8;
    localparam int B_ARLO   = 9;
    localparam int B_OVR    = 10;
    localparam int B_PEC    = 11;
    localparam int B_TMO    = 12;
    localparam int B_ALERT  = 13;
    localparam int B_DIR    = 14;

    // Flags that are set by an event pulse and cleared only by write-one-to-clear.
    localparam logic [FLAG_W-1:0] STICKY_MASK =
        (FLAG_W'(1) << B_ADDR) | (FLAG_W'(1) << B_NACK) | (FLAG_W'(1) << B_STOP) |
        (FLAG_W'(1) << B_BERR) | (FLAG_W'(1) << B_ARLO) | (FLAG_W'(1) << B_OVR)  |
        (FLAG_W'(1) << B_PEC)  | (FLAG_W'(1) << B_TMO)  | (FLAG_W'(1) << B_ALERT);

    // Flags that exist only when SMBus support is built in.
    localparam logic [FLAG_W-1:0] SMB_MASK =
        (FLAG_W'(1) << B_PEC) | (FLAG_W'(1) << B_TMO) | (FLAG_W'(1) << B_ALERT);

    // Value of the whole vector after reset or while disabled.
    localparam logic [FLAG_W-1:0] IDLE_FLAGS = FLAG_W'(1) << B_TXE;
endpackage

// File: rtl/i2c_isr_sticky_bank.sv
// Module: bank of sticky error/event flags.
// Each kept flag is set by its event pulse and cleared by a write-one-to-clear.
// Set wins over clear at the same edge. Disable clears all flags.
// Assumes event pulses are one cycle wide; positions outside the sticky mask,
// or SMBus positions when SMBUS_EN=0, are tied to 0.
module i2c_isr_sticky_bank
    import i2c_isr_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_data_i,
    output logic [FLAG_W-1:0] sticky_o
);
    localparam logic [FLAG_W-1:0] KEEP_MASK =
        SMBUS_EN ? STICKY_MASK : (STICKY_MASK & ~SMB_MASK);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (KEEP_MASK[i]) begin : g_flop
            logic flag_q;
            // Purpose: hold one sticky flag; disable > set > clear.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable_i)          flag_q <= 1'b0;
                else if (evt_i[i])                flag_q <= 1'b1;
                else if (clr_we_i && clr_data_i[i]) flag_q <= 1'b0;
            end
            assign sticky_o[i] = flag_q;
        end else begin : g_tie
            logic unused_in;
            assign unused_in   = evt_i[i] ^ clr_data_i[i];
            assign sticky_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_isr_tx_flags.sv
// Module: transmit-empty and transmit-interrupt flags plus the software TX event.
// Transmit-empty idles at 1 (reset and disable) and can be set by a flush write.
// Transmit-interrupt may be set by software only while clock stretching is off.
// Assumes strobes are one cycle wide; set sources win over the data-register write.
module i2c_isr_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic nostretch_i,
    input  logic tx_empty_i,
    input  logic txdr_wr_i,
    input  logic sts_we_i,
    input  logic flush_bit_i,
    input  logic txis_bit_i,
    output logic txe_o,
    output logic txis_o,
    output logic txev_o
);
    logic txe_q, txis_q, txev_q;
    logic flush_req, sw_txis_req;

    // Purpose: qualify the two software writes into the status register.
    always_comb begin
        flush_req   = sts_we_i && flush_bit_i;
        sw_txis_req = sts_we_i && txis_bit_i && nostretch_i;
    end

    // Purpose: transmit-empty flag; idle value 1.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i)          txe_q <= 1'b1;
        else if (tx_empty_i || flush_req) txe_q <= 1'b1;
        else if (txdr_wr_i)               txe_q <= 1'b0;
    end

    // Purpose: transmit-interrupt flag; idle value 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i)            txis_q <= 1'b0;
        else if (tx_empty_i || sw_txis_req) txis_q <= 1'b1;
        else if (txdr_wr_i)                 txis_q <= 1'b0;
    end

    // Purpose: one-cycle transmit event after an accepted software set.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) txev_q <= 1'b0;
        else                     txev_q <= sw_txis_req;
    end

    assign txe_o  = txe_q;
    assign txis_o = txis_q;
    assign txev_o = txev_q;
endmodule

// File: rtl/i2c_isr_xfer_flags.sv
// Module: receive-not-empty, transfer-complete, reload-complete and direction.
// Each flag has its own clear route; set wins over clear at the same edge.
// Assumes pulses are one cycle wide and that reload/autoend are stable around
// the count-done pulse.
module i2c_isr_xfer_flags #(
    parameter int NB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable_i,
    input  logic            reload_i,
    input  logic            autoend_i,
    input  logic            rx_byte_i,
    input  logic            rxdr_rd_i,
    input  logic            cnt_done_i,
    input  logic            addr_evt_i,
    input  logic            dir_i,
    input  logic            start_wr_i,
    input  logic            stop_wr_i,
    input  logic            nbytes_wr_i,
    input  logic [NB_W-1:0] nbytes_val_i,
    output logic            rxne_o,
    output logic            tc_o,
    output logic            tcr_o,
    output logic            dir_o
);
    logic rxne_q, tc_q, tcr_q, dir_q;
    logic tc_set, tcr_set, tc_clr, tcr_clr;

    // Purpose: decode set and clear conditions for the count flags.
    always_comb begin
        tcr_set = cnt_done_i && reload_i;
        tc_set  = cnt_done_i && !reload_i && !autoend_i;
        tc_clr  = start_wr_i || stop_wr_i;
        tcr_clr = nbytes_wr_i && (|nbytes_val_i);
    end

    // Purpose: receive data register holds an unread byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) rxne_q <= 1'b0;
        else if (rx_byte_i)      rxne_q <= 1'b1;
        else if (rxdr_rd_i)      rxne_q <= 1'b0;
    end

    // Purpose: transfer complete without reload or auto-end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) tc_q <= 1'b0;
        else if (tc_set)         tc_q <= 1'b1;
        else if (tc_clr)         tc_q <= 1'b0;
    end

    // Purpose: byte count exhausted in reload mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) tcr_q <= 1'b0;
        else if (tcr_set)        tcr_q <= 1'b1;
        else if (tcr_clr)        tcr_q <= 1'b0;
    end

    // Purpose: capture transfer direction on an address match only.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) dir_q <= 1'b0;
        else if (addr_evt_i)     dir_q <= dir_i;
    end

    assign rxne_o = rxne_q;
    assign tc_o   = tc_q;
    assign tcr_o  = tcr_q;
    assign dir_o  = dir_q;
endmodule

// File: rtl/i2c_isr_flags.sv
// Module: top of the I2C status flag block.
// Assembles the sticky bank, transmit flags and transfer flags into one
// vector and drives the masked interrupt request.
// Assumes all strobes and event pulses are synchronous to clk and one cycle wide.
module i2c_isr_flags
    import i2c_isr_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1,
    parameter int NB_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              nostretch_i,
    input  logic              reload_i,
    input  logic              autoend_i,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              tx_empty_i,
    input  logic              rx_byte_i,
    input  logic              cnt_done_i,
    input  logic              dir_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_data_i,
    input  logic              sts_we_i,
    input  logic [FLAG_W-1:0] sts_wdata_i,
    input  logic              txdr_wr_i,
    input  logic              rxdr_rd_i,
    input  logic              start_wr_i,
    input  logic              stop_wr_i,
    input  logic              nbytes_wr_i,
    input  logic [NB_W-1:0]   nbytes_val_i,
    input  logic [FLAG_W-1:0] irq_en_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o,
    output logic              txev_o
);
    logic [FLAG_W-1:0] sticky;
    logic              txe, txis, rxne, tc, tcr, dirf;
    logic [FLAG_W-1:0] flags;
    logic              unused_sts;

    assign unused_sts = ^sts_wdata_i[FLAG_W-1:2];

    i2c_isr_sticky_bank #(.SMBUS_EN(SMBUS_EN)) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .evt_i      (evt_i),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .sticky_o   (sticky)
    );

    i2c_isr_tx_flags u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .nostretch_i (nostretch_i),
        .tx_empty_i  (tx_empty_i),
        .txdr_wr_i   (txdr_wr_i),
        .sts_we_i    (sts_we_i),
        .flush_bit_i (sts_wdata_i[B_TXE]),
        .txis_bit_i  (sts_wdata_i[B_TXIS]),
        .txe_o       (txe),
        .txis_o      (txis),
        .txev_o      (txev_o)
    );

    i2c_isr_xfer_flags #(.NB_W(NB_W)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .reload_i     (reload_i),
        .autoend_i    (autoend_i),
        .rx_byte_i    (rx_byte_i),
        .rxdr_rd_i    (rxdr_rd_i),
        .cnt_done_i   (cnt_done_i),
        .addr_evt_i   (evt_i[B_ADDR]),
        .dir_i        (dir_i),
        .start_wr_i   (start_wr_i),
        .stop_wr_i    (stop_wr_i),
        .nbytes_wr_i  (nbytes_wr_i),
        .nbytes_val_i (nbytes_val_i),
        .rxne_o       (rxne),
        .tc_o         (tc),
        .tcr_o        (tcr),
        .dir_o        (dirf)
    );

    // Purpose: merge all flag sources into the published bit map.
    always_comb begin
        flags          = sticky;
        flags[B_TXE]   = txe;
        flags[B_TXIS]  = txis;
        flags[B_RXNE]  = rxne;
        flags[B_TC]    = tc;
        flags[B_TCR]   = tcr;
        flags[B_DIR]   = dirf;
    end

    assign flags_o = flags;

    // Purpose: combined interrupt request from enabled flags.
    assign irq_o = |(flags & irq_en_i);
endmodule

// File: rtl/i2c_isr_flags_chk.sv
// Checker: temporal properties of the I2C status flags, bound to the top.
module i2c_isr_flags_chk
    import i2c_isr_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1,
    parameter int NB_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              nostretch_i,
    input logic              reload_i,
    input logic              autoend_i,
    input logic [FLAG_W-1:0] evt_i,
    input logic              tx_empty_i,
    input logic              rx_byte_i,
    input logic              cnt_done_i,
    input logic              dir_i,
    input logic              clr_we_i,
    input logic [FLAG_W-1:0] clr_data_i,
    input logic              sts_we_i,
    input logic [FLAG_W-1:0] sts_wdata_i,
    input logic              txdr_wr_i,
    input logic              rxdr_rd_i,
    input logic              start_wr_i,
    input logic              stop_wr_i,
    input logic              nbytes_wr_i,
    input logic [NB_W-1:0]   nbytes_val_i,
    input logic [FLAG_W-1:0] irq_en_i,
    input logic [FLAG_W-1:0] flags_o,
    input logic              irq_o,
    input logic              txev_o
);
    localparam logic [FLAG_W-1:0] LIVE_STICKY =
        SMBUS_EN ? STICKY_MASK : (STICKY_MASK & ~SMB_MASK);

    // R1: disabled means idle vector one edge later
    a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> flags_o == IDLE_FLAGS);

    // R2: sticky flags hold while no clear is written
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !clr_we_i) |=>
        ((flags_o & $past(flags_o) & LIVE_STICKY) == ($past(flags_o) & LIVE_STICKY)));

    // R3: set event wins over same-edge clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |=> ((flags_o & $past(evt_i & LIVE_STICKY)) == $past(evt_i & LIVE_STICKY)));

    // R4: received byte raises receive-not-empty
    a_r4_rxne_set: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && rx_byte_i) |=> flags_o[B_RXNE]);

    // R5: data write clears both transmit flags when no set source is present
    a_r5_txdr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && txdr_wr_i && !tx_empty_i && !sts_we_i) |=>
        (!flags_o[B_TXE] && !flags_o[B_TXIS]));

    // R6: flush write sets transmit-empty
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && sts_we_i && sts_wdata_i[B_TXE]) |=> flags_o[B_TXE]);

    // R7: no transmit event while stretching is allowed
    a_r7_no_txev: assert property (@(posedge clk) disable iff (!rst_n)
        !nostretch_i |=> !txev_o);

    // R8: count done in reload mode raises reload-complete
    a_r8_tcr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cnt_done_i && reload_i) |=> flags_o[B_TCR]);

    // R9: count done without reload or auto-end raises transfer-complete
    a_r9_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cnt_done_i && !reload_i && !autoend_i) |=> flags_o[B_TC]);

    // R10: direction changes only on an address event
    a_r10_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !evt_i[B_ADDR]) |=> $stable(flags_o[B_DIR]));

    // R12: interrupt follows enabled flags
    a_r12_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ($countones(flags_o & irq_en_i) != 0));

    if (!SMBUS_EN) begin : g_nosmb
        // R11: SMBus flags absent
        a_r11_smb_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o & SMB_MASK) == '0);
    end
endmodule

bind i2c_isr_flags i2c_isr_flags_chk #(.SMBUS_EN(SMBUS_EN), .NB_W(NB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .nostretch_i(nostretch_i),
    .reload_i(reload_i), .autoend_i(autoend_i), .evt_i(evt_i),
    .tx_empty_i(tx_empty_i), .rx_byte_i(rx_byte_i), .cnt_done_i(cnt_done_i),
    .dir_i(dir_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i), .txdr_wr_i(txdr_wr_i),
    .rxdr_rd_i(rxdr_rd_i), .start_wr_i(start_wr_i), .stop_wr_i(stop_wr_i),
    .nbytes_wr_i(nbytes_wr_i), .nbytes_val_i(nbytes_val_i), .irq_en_i(irq_en_i),
    .flags_o(flags_o), .irq_o(irq_o), .txev_o(txev_o)
);

// File: tb/i2c_isr_flags_bench.sv
module i2c_isr_flags_bench;
    localparam int FW = 16;
    localparam int NBW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, nostretch_i = 1'b0, reload_i = 1'b0, autoend_i = 1'b0;
    logic [FW-1:0] evt_i = '0, clr_data_i = '0, sts_wdata_i = '0, irq_en_i = '0;
    logic tx_empty_i = 0, rx_byte_i = 0, cnt_done_i = 0, dir_i = 0, clr_we_i = 0;
    logic sts_we_i = 0, txdr_wr_i = 0, rxdr_rd_i = 0, start_wr_i = 0, stop_wr_i = 0;
    logic nbytes_wr_i = 0;
    logic [NBW-1:0] nbytes_val_i = '0;
    logic [FW-1:0] flags_o, flags_n;
    logic irq_o, txev_o, irq_n, txev_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_isr_flags #(.SMBUS_EN(1'b1), .NB_W(NBW)) u_i2c_isr_flags (
        .clk, .rst_n, .enable_i, .nostretch_i, .reload_i, .autoend_i, .evt_i,
        .tx_empty_i, .rx_byte_i, .cnt_done_i, .dir_i, .clr_we_i, .clr_data_i,
        .sts_we_i, .sts_wdata_i, .txdr_wr_i, .rxdr_rd_i, .start_wr_i, .stop_wr_i,
        .nbytes_wr_i, .nbytes_val_i, .irq_en_i, .flags_o, .irq_o, .txev_o);

    i2c_isr_flags #(.SMBUS_EN(1'b0), .NB_W(NBW)) u_nosmb (
        .clk, .rst_n, .enable_i, .nostretch_i, .reload_i, .autoend_i, .evt_i,
        .tx_empty_i, .rx_byte_i, .cnt_done_i, .dir_i, .clr_we_i, .clr_data_i,
        .sts_we_i, .sts_wdata_i, .txdr_wr_i, .rxdr_rd_i, .start_wr_i, .stop_wr_i,
        .nbytes_wr_i, .nbytes_val_i, .irq_en_i, .flags_o(flags_n), .irq_o(irq_n),
        .txev_o(txev_n));

    task automatic check(input string req, input logic [FW-1:0] got, input logic [FW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply the currently driven strobes at one edge, then drop all strobes.
    task automatic tick();
        @(posedge clk); #2;
        evt_i = '0; tx_empty_i = 0; rx_byte_i = 0; cnt_done_i = 0; clr_we_i = 0;
        clr_data_i = '0; sts_we_i = 0; sts_wdata_i = '0; txdr_wr_i = 0; rxdr_rd_i = 0;
        start_wr_i = 0; stop_wr_i = 0; nbytes_wr_i = 0; nbytes_val_i = '0;
    endtask

    task automatic t_reset();
        check("R1 reset vector", flags_o, 16'h0001);
        check("R12 irq idle", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_sticky();
        evt_i = 16'h0010; tick();
        check("R2 nack set", flags_o & 16'h0010, 16'h0010);
        clr_we_i = 1; clr_data_i = 16'h0020; tick();
        check("R2 other clear bit keeps nack", flags_o & 16'h0010, 16'h0010);
        clr_we_i = 1; clr_data_i = 16'h0010; tick();
        check("R2 nack cleared", flags_o & 16'h0010, 16'h0000);
        evt_i = 16'h0040; tick();
        check("R2 event at tc position ignored", flags_o & 16'h0040, 16'h0000);
    endtask

    task automatic t_same_edge();
        evt_i = 16'h0100; clr_we_i = 1; clr_data_i = 16'h0100; tick();
        check("R3 set wins over clear", flags_o & 16'h0100, 16'h0100);
        clr_we_i = 1; clr_data_i = 16'h0100; tick();
    endtask

    task automatic t_rx();
        rx_byte_i = 1; tick();
        check("R4 rxne set", flags_o & 16'h0004, 16'h0004);
        rxdr_rd_i = 1; tick();
        check("R4 rxne cleared", flags_o & 16'h0004, 16'h0000);
    endtask

    task automatic t_tx();
        txdr_wr_i = 1; tick();
        check("R5 write clears txe/txis", flags_o & 16'h0003, 16'h0000);
        tx_empty_i = 1; tick();
        check("R5 empty sets txe/txis", flags_o & 16'h0003, 16'h0003);
        txdr_wr_i = 1; tick();
        check("R5 write clears again", flags_o & 16'h0003, 16'h0000);
        sts_we_i = 1; sts_wdata_i = 16'h0001; tick();
        check("R6 flush sets txe only", flags_o & 16'h0003, 16'h0001);
    endtask

    task automatic t_txis_sw();
        nostretch_i = 0; sts_we_i = 1; sts_wdata_i = 16'h0002; tick();
        check("R7 ignored txis", flags_o & 16'h0002, 16'h0000);
        check("R7 no txev", {15'd0, txev_o}, 16'd0);
        nostretch_i = 1; sts_we_i = 1; sts_wdata_i = 16'h0002; tick();
        check("R7 txis set", flags_o & 16'h0002, 16'h0002);
        check("R7 txev pulse", {15'd0, txev_o}, 16'd1);
        tick();
        check("R7 txev one cycle", {15'd0, txev_o}, 16'd0);
        nostretch_i = 0; txdr_wr_i = 1; tick();
    endtask

    task automatic t_tcr();
        reload_i = 1; cnt_done_i = 1; tick();
        check("R8 tcr set", flags_o & 16'h00C0, 16'h0080);
        nbytes_wr_i = 1; nbytes_val_i = 8'd0; tick();
        check("R8 zero count keeps tcr", flags_o & 16'h0080, 16'h0080);
        nbytes_wr_i = 1; nbytes_val_i = 8'd5; tick();
        check("R8 nonzero count clears tcr", flags_o & 16'h0080, 16'h0000);
        reload_i = 0;
    endtask

    task automatic t_tc();
        autoend_i = 1; cnt_done_i = 1; tick();
        check("R9 autoend blocks tc", flags_o & 16'h00C0, 16'h0000);
        autoend_i = 0; cnt_done_i = 1; tick();
        check("R9 tc set", flags_o & 16'h0040, 16'h0040);
        stop_wr_i = 1; tick();
        check("R9 stop clears tc", flags_o & 16'h0040, 16'h0000);
        cnt_done_i = 1; tick();
        start_wr_i = 1; tick();
        check("R9 start clears tc", flags_o & 16'h0040, 16'h0000);
    endtask

    task automatic t_dir();
        dir_i = 1; tick();
        check("R10 dir needs address event", flags_o & 16'h4000, 16'h0000);
        dir_i = 1; evt_i = 16'h0008; tick();
        check("R10 dir captured", flags_o & 16'h4008, 16'h4008);
        dir_i = 0; tick();
        check("R10 dir held", flags_o & 16'h4000, 16'h4000);
        clr_we_i = 1; clr_data_i = 16'h0008; tick();
    endtask

    task automatic t_smbus();
        evt_i = 16'h3800; tick();
        check("R11 smbus flags present", flags_o & 16'h3800, 16'h3800);
        check("R11 smbus flags absent", flags_n & 16'h3800, 16'h0000);
        clr_we_i = 1; clr_data_i = 16'h3800; tick();
    endtask

    task automatic t_irq();
        evt_i = 16'h0200; irq_en_i = 16'h0200; tick();
        check("R12 irq on enabled flag", {15'd0, irq_o}, 16'd1);
        irq_en_i = 16'h0400; #1;
        check("R12 irq masked", {15'd0, irq_o}, 16'd0);
        irq_en_i = 16'h0000;
    endtask

    task automatic t_disable();
        evt_i = 16'h0030; rx_byte_i = 1; txdr_wr_i = 1; tick();
        enable_i = 0; evt_i = 16'h0010; rx_byte_i = 1; txdr_wr_i = 1; tick();
        check("R1 disable forces idle", flags_o, 16'h0001);
        evt_i = 16'h3F38; tick();
        check("R1 events ignored while disabled", flags_o, 16'h0001);
        enable_i = 1; tick();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        t_reset();
        enable_i = 1; tick();
        t_sticky();
        t_same_edge();
        t_rx();
        t_tx();
        t_txis_sw();
        t_tcr();
        t_tc();
        t_dir();
        t_smbus();
        t_irq();
        t_disable();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule